// File: doc/BRIEF.md
# Programmable Color Space Matrix

This block applies a programmable 3×3 matrix with per-row offsets to a video stream. It accepts one pixel per clock and produces one converted pixel per clock, for example RGB to YCbCr or back. Each output component is a weighted sum of the three input components plus an offset. The weights are signed fixed-point values with twelve fraction bits. A shared mode field scales every weight and offset by one, two or four.

The matrix coefficients, offsets and mode arrive on static configuration ports. They are copied into an internal working set only while no pixel is entering or in flight, so a frame never sees a half-changed matrix. The valid flag moves through the pipeline with the pixel. Horizontal sync, vertical sync and data enable are delayed by the same number of cycles, so they stay aligned with the converted data.

Top module: `csc_matrix`

## Requirements
- R1: While reset is asserted, and right after it, `validOut`, `hsOut`, `vsOut`, `deOut` and every `pixOut` component are zero.
- R2: For output row r, the block computes the clamp of round((Σk C[r][k]·X[k]·2^s)/4096) + O[r]·2^s. C and O are 13-bit two's complement values. X[0], X[1] and X[2] are the unsigned 12-bit input components in the order R/Cr, G/Y, B/Cb. `cfgCoef[r][k]` holds C[r][k], `cfgOffset[r]` holds O[r], and `pixOut[r]` is output row r.
- R3: The division by 4096 rounds to nearest, and an exact half rounds toward plus infinity. Negative sums round the same way: −1.5 becomes −1.
- R4: The shift s is 0, 1 or 2 for `cfgMode` values 0, 1 or 2. A mode value of 3 behaves exactly like mode 2.
- R5: Each output component is saturated to the range 0 to 4095.
- R6: A pixel taken with `validIn` high at a rising edge appears on `pixOut` with `validOut` high after the third rising edge. The block accepts a new pixel on every clock with no gaps.
- R7: `hsOut`, `vsOut` and `deOut` equal `hsIn`, `vsIn` and `deIn` delayed by exactly three clocks, whatever `validIn` is doing.
- R8: While `validOut` is low, `pixOut` holds the last converted pixel.
- R9: The configuration ports are copied into the working set only at an edge where `validIn` is low and no pixel sits in the first two pipeline stages. Port changes at any other time have no effect on the output until such an edge occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Asynchronous reset, active low |
| validIn | input | 1 | Marks a pixel on `pixIn` |
| hsIn | input | 1 | Horizontal sync in |
| vsIn | input | 1 | Vertical sync in |
| deIn | input | 1 | Data enable in |
| pixIn | input | 3×12 | Input components; index 0 R/Cr, 1 G/Y, 2 B/Cb |
| cfgCoef | input | 3×3×13 | Coefficients, [row][input], signed, divided by 4096 |
| cfgOffset | input | 3×13 | Per-row signed offset in output units |
| cfgMode | input | 2 | Global scale: ×2^mode, with 3 treated as 2 |
| validOut | output | 1 | Marks a converted pixel on `pixOut` |
| hsOut | output | 1 | Horizontal sync, delayed 3 clocks |
| vsOut | output | 1 | Vertical sync, delayed 3 clocks |
| deOut | output | 1 | Data enable, delayed 3 clocks |
| pixOut | output | 3×12 | Converted components, index = matrix row |

## Verification
Every result of this block is due exactly three clocks after its stimulus: the converted pixel with its valid flag, and the three sync and enable flags. The bench drives inputs on the falling edge and keeps eight cycles of driven stimulus, each entry with its expected pixel computed arithmetically. On each falling edge it compares the outputs against the entry driven three falling edges earlier. Configuration loads are modeled the same way. The bench copies a new configuration into its own model only after an idle stretch, so pixels streamed across a port change are still checked against the old matrix.

// File: rtl/csc_pkg.sv
package csc_pkg;
  localparam int COEF_W     = 13;  // signed coefficient / offset width
  localparam int FRAC_W     = 12;  // coefficient fraction bits (divide by 4096)
  localparam int MODE_W     = 2;   // global scale field width
  localparam int MAX_SHIFT  = 2;   // largest scale exponent
  localparam int SHIFT_W    = 2;   // width of clamped scale exponent
  localparam int ROWS       = 3;   // matrix rows == input components
  localparam int PIPE_DEPTH = 3;   // multiply, sum, round/clamp

  typedef struct packed {
    logic [ROWS-1:0][ROWS-1:0][COEF_W-1:0] coef;
    logic [ROWS-1:0][COEF_W-1:0]           offset;
    logic [SHIFT_W-1:0]                    shift;
  } matrixCfg_t;

  typedef struct packed {
    logic                  loadCfg;
    logic [PIPE_DEPTH-1:0] stageEn;  // [0] multiply, [1] sum, [2] output
  } pipeStrobe_t;
endpackage

// File: rtl/csc_ctrl.sv
module csc_ctrl
  import csc_pkg::*;
(
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  validIn,
  input  logic [ROWS-1:0][ROWS-1:0][COEF_W-1:0] cfgCoef,
  input  logic [ROWS-1:0][COEF_W-1:0]           cfgOffset,
  input  logic [MODE_W-1:0]                     cfgMode,
  output pipeStrobe_t                           strobe,
  output matrixCfg_t                            activeCfg,
  output logic                                  validOut
);
  // occupancy[i] is high when stage i+1 holds a pixel
  logic [PIPE_DEPTH-1:0] occupancy;
  logic                  pipeQuiet;
  logic [SHIFT_W-1:0]    shiftNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) occupancy <= '0;
    else       occupancy <= {occupancy[PIPE_DEPTH-2:0], validIn};
  end

  // stages 2 and 3 read the working set, so they must be empty too
  assign pipeQuiet = !validIn && (occupancy[PIPE_DEPTH-2:0] == '0);

  always_comb begin
    if (int'(cfgMode) > MAX_SHIFT) shiftNext = SHIFT_W'(MAX_SHIFT);
    else                           shiftNext = SHIFT_W'(cfgMode);
  end

  always_comb begin
    strobe.loadCfg = pipeQuiet;
    strobe.stageEn = {occupancy[PIPE_DEPTH-2:0], validIn};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      activeCfg <= '0;
    end else if (strobe.loadCfg) begin
      activeCfg.coef   <= cfgCoef;
      activeCfg.offset <= cfgOffset;
      activeCfg.shift  <= shiftNext;
    end
  end

  assign validOut = occupancy[PIPE_DEPTH-1];
endmodule

// File: rtl/csc_datapath.sv
module csc_datapath
  import csc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pipeStrobe_t                  strobe,
  input  matrixCfg_t                   activeCfg,
  input  logic [ROWS-1:0][DATA_W-1:0]  pixIn,
  input  logic                         hsIn,
  input  logic                         vsIn,
  input  logic                         deIn,
  output logic [ROWS-1:0][DATA_W-1:0]  pixOut,
  output logic                         hsOut,
  output logic                         vsOut,
  output logic                         deOut
);
  localparam int PROD_W   = COEF_W + DATA_W + 1;
  localparam int SCALED_W = PROD_W + 2 + MAX_SHIFT;
  localparam int ROUND_W  = SCALED_W - FRAC_W;
  localparam int OFFS_W   = COEF_W + MAX_SHIFT;
  localparam int FINAL_W  = ((ROUND_W > OFFS_W) ? ROUND_W : OFFS_W) + 1;
  localparam int SB_W     = 3;
  localparam logic signed [SCALED_W-1:0] HALF_LSB = SCALED_W'(1) <<< (FRAC_W - 1);
  localparam logic signed [FINAL_W-1:0]  PIX_MAX  = FINAL_W'((1 << DATA_W) - 1);

  logic signed [PROD_W-1:0]   prodQ   [ROWS][ROWS];
  logic signed [SCALED_W-1:0] scaledQ [ROWS];
  logic [DATA_W-1:0]          pixNext [ROWS];
  logic [PIPE_DEPTH-1:0][SB_W-1:0] sbPipe;

  // stage 1: nine products
  for (genvar r = 0; r < ROWS; r++) begin : gRowMul
    for (genvar c = 0; c < ROWS; c++) begin : gColMul
      logic signed [PROD_W-1:0] coefWide;
      logic signed [PROD_W-1:0] pixWide;
      assign coefWide = PROD_W'($signed(activeCfg.coef[r][c]));
      assign pixWide  = PROD_W'($signed({1'b0, pixIn[c]}));
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                  prodQ[r][c] <= '0;
        else if (strobe.stageEn[0]) prodQ[r][c] <= coefWide * pixWide;
      end
    end
  end

  // stage 2: row sums with the global scale
  for (genvar r = 0; r < ROWS; r++) begin : gRowSum
    logic signed [SCALED_W-1:0] sumWide;
    assign sumWide = SCALED_W'(prodQ[r][0]) + SCALED_W'(prodQ[r][1]) + SCALED_W'(prodQ[r][2]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  scaledQ[r] <= '0;
      else if (strobe.stageEn[1]) scaledQ[r] <= sumWide <<< activeCfg.shift;
    end
  end

  // stage 3: round, add scaled offset, saturate
  for (genvar r = 0; r < ROWS; r++) begin : gRowOut
    logic signed [SCALED_W-1:0] biased;
    logic signed [ROUND_W-1:0]  rounded;
    logic signed [OFFS_W-1:0]   offScaled;
    logic signed [FINAL_W-1:0]  total;
    always_comb begin
      biased    = scaledQ[r] + HALF_LSB;
      rounded   = $signed(biased[SCALED_W-1:FRAC_W]);
      offScaled = OFFS_W'($signed(activeCfg.offset[r])) <<< activeCfg.shift;
      total     = FINAL_W'(rounded) + FINAL_W'(offScaled);
      if (total < 0)            pixNext[r] = '0;
      else if (total > PIX_MAX) pixNext[r] = PIX_MAX[DATA_W-1:0];
      else                      pixNext[r] = total[DATA_W-1:0];
    end
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                  pixOut[r] <= '0;
      else if (strobe.stageEn[2]) pixOut[r] <= pixNext[r];
    end
  end

  // sync and enable flags: free-running delay line
  for (genvar s = 0; s < PIPE_DEPTH; s++) begin : gSideband
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)       sbPipe[s] <= '0;
      else if (s == 0) sbPipe[s] <= {hsIn, vsIn, deIn};
      else             sbPipe[s] <= sbPipe[(s == 0) ? 0 : s-1];
    end
  end

  assign {hsOut, vsOut, deOut} = sbPipe[PIPE_DEPTH-1];
endmodule

// File: rtl/csc_matrix.sv
module csc_matrix
  import csc_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  validIn,
  input  logic                                  hsIn,
  input  logic                                  vsIn,
  input  logic                                  deIn,
  input  logic [ROWS-1:0][DATA_W-1:0]           pixIn,
  input  logic [ROWS-1:0][ROWS-1:0][COEF_W-1:0] cfgCoef,
  input  logic [ROWS-1:0][COEF_W-1:0]           cfgOffset,
  input  logic [MODE_W-1:0]                     cfgMode,
  output logic                                  validOut,
  output logic                                  hsOut,
  output logic                                  vsOut,
  output logic                                  deOut,
  output logic [ROWS-1:0][DATA_W-1:0]           pixOut
);
  pipeStrobe_t strobe;
  matrixCfg_t  activeCfg;

  csc_ctrl uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .validIn   (validIn),
    .cfgCoef   (cfgCoef),
    .cfgOffset (cfgOffset),
    .cfgMode   (cfgMode),
    .strobe    (strobe),
    .activeCfg (activeCfg),
    .validOut  (validOut)
  );

  csc_datapath #(.DATA_W(DATA_W)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .activeCfg (activeCfg),
    .pixIn     (pixIn),
    .hsIn      (hsIn),
    .vsIn      (vsIn),
    .deIn      (deIn),
    .pixOut    (pixOut),
    .hsOut     (hsOut),
    .vsOut     (vsOut),
    .deOut     (deOut)
  );
endmodule

// File: rtl/csc_matrix_chk.sv
module csc_matrix_chk #(
  parameter int DATA_W = 12
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  validIn,
  input logic                  hsIn,
  input logic                  vsIn,
  input logic                  deIn,
  input logic                  validOut,
  input logic                  hsOut,
  input logic                  vsOut,
  input logic                  deOut,
  input logic [2:0][DATA_W-1:0] pixOut
);
  logic [1:0] sinceReset;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                   sinceReset <= '0;
    else if (sinceReset != 2'd3) sinceReset <= sinceReset + 2'd1;
  end

  // R6
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (validOut == $past(validIn, 3)));

  // R7
  hs_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (hsOut == $past(hsIn, 3)));

  // R7
  vs_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (vsOut == $past(vsIn, 3)));

  // R7
  de_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinceReset == 2'd3) |-> (deOut == $past(deIn, 3)));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((sinceReset != 2'd0) && !validOut) |-> $stable(pixOut));
endmodule

bind csc_matrix csc_matrix_chk #(.DATA_W(DATA_W)) uChk (
  .clk      (clk),
  .rstN     (rstN),
  .validIn  (validIn),
  .hsIn     (hsIn),
  .vsIn     (vsIn),
  .deIn     (deIn),
  .validOut (validOut),
  .hsOut    (hsOut),
  .vsOut    (vsOut),
  .deOut    (deOut),
  .pixOut   (pixOut)
);

// File: tb/sim_csc_matrix.sv
`timescale 1ns/1ps
module sim_csc_matrix;
  localparam int DW = 12;

  logic clk = 1'b0;
  logic rstN;
  logic validIn, hsIn, vsIn, deIn;
  logic [2:0][DW-1:0] pixIn;
  logic [2:0][2:0][12:0] cfgCoef;
  logic [2:0][12:0] cfgOffset;
  logic [1:0] cfgMode;
  logic validOut, hsOut, vsOut, deOut;
  logic [2:0][DW-1:0] pixOut;

  always #5 clk = ~clk;

  csc_matrix #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .validIn(validIn), .hsIn(hsIn), .vsIn(vsIn), .deIn(deIn),
    .pixIn(pixIn), .cfgCoef(cfgCoef), .cfgOffset(cfgOffset), .cfgMode(cfgMode),
    .validOut(validOut), .hsOut(hsOut), .vsOut(vsOut), .deOut(deOut), .pixOut(pixOut)
  );

  int checks = 0;
  int errors = 0;
  int tickN = 0;
  string tag = "R2";

  // port-side and model-side configuration
  int pC[3][3], pO[3], pM;
  int mC[3][3], mO[3], mM;

  bit hV[8], hH[8], hS[8], hD[8];
  int hE[8][3];
  int lastOut[3] = '{0, 0, 0};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (tick %0d)", req, act, exp, tickN);
    end
  endtask

  function automatic int model(int row, int x0, int x1, int x2);
    int sc, acc, r, v;
    sc  = 1 << ((mM > 2) ? 2 : mM);
    acc = (mC[row][0] * x0 + mC[row][1] * x1 + mC[row][2] * x2) * sc;
    r   = (acc + 2048) >>> 12;
    v   = r + mO[row] * sc;
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic drivePorts();
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) cfgCoef[r][c] = 13'(pC[r][c]);
      cfgOffset[r] = 13'(pO[r]);
    end
    cfgMode = 2'(pM);
  endtask

  task automatic setDiag(int c, int off, int mode);
    for (int r = 0; r < 3; r++) begin
      for (int k = 0; k < 3; k++) pC[r][k] = (r == k) ? c : 0;
      pO[r] = off;
    end
    pM = mode;
    drivePorts();
  endtask

  task automatic tick(bit v, int x0, int x1, int x2);
    int idx;
    @(negedge clk);
    if (tickN >= 3) begin
      idx = (tickN - 3) % 8;
      chk("R6", int'(validOut), int'(hV[idx]));
      chk("R7", int'({hsOut, vsOut, deOut}), int'({hH[idx], hS[idx], hD[idx]}));
      for (int r = 0; r < 3; r++) begin
        if (hV[idx]) begin
          chk(tag, int'(pixOut[r]), hE[idx][r]);
          lastOut[r] = hE[idx][r];
        end else begin
          chk("R8", int'(pixOut[r]), lastOut[r]);
        end
      end
    end
    idx = tickN % 8;
    validIn  = v;
    pixIn[0] = DW'(x0);
    pixIn[1] = DW'(x1);
    pixIn[2] = DW'(x2);
    hsIn = ((tickN * 7) % 11) < 3;
    vsIn = ((tickN * 5) % 13) < 2;
    deIn = ((tickN * 3) % 7) > 2;
    hV[idx] = v; hH[idx] = hsIn; hS[idx] = vsIn; hD[idx] = deIn;
    for (int r = 0; r < 3; r++) hE[idx][r] = model(r, x0, x1, x2);
    tickN++;
  endtask

  // idle long enough for the working set to reload, then mirror it
  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick(1'b0, 0, 0, 0);
    mC = pC; mO = pO; mM = pM;
  endtask

  task automatic sweep(int n, int step);
    for (int i = 0; i < n; i++)
      tick(1'b1, (i * step) % 4096, (4095 - i * step % 4096), (i * 7 * step + 123) % 4096);
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0;
    validIn = 1'b0; hsIn = 1'b0; vsIn = 1'b0; deIn = 1'b0; pixIn = '0;
    for (int r = 0; r < 3; r++) begin
      for (int c = 0; c < 3; c++) begin pC[r][c] = 0; mC[r][c] = 0; end
      pO[r] = 0; mO[r] = 0;
    end
    pM = 0; mM = 0;
    drivePorts();
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", int'({validOut, hsOut, vsOut, deOut}), 0);
    for (int r = 0; r < 3; r++) chk("R1", int'(pixOut[r]), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1", int'({validOut, hsOut, vsOut, deOut}), 0);

    // R2 / R4: unity matrix in mode 1 and mode 2, every pixel back unchanged
    tag = "R2"; setDiag(2048, 0, 1); idle(4); sweep(300, 13);
    tag = "R4"; setDiag(1024, 0, 2); idle(4); sweep(200, 19);
    // R4: mode 3 behaves as mode 2
    tag = "R4"; setDiag(1024, 0, 3); idle(4); sweep(200, 23);
    tag = "R4"; setDiag(700, -5, 3); idle(4); sweep(150, 29);

    // R2: full matrix with signed coefficients and offsets, every mode
    tag = "R2";
    for (int m = 0; m < 3; m++) begin
      pC[0][0] = 1254;  pC[0][1] = 2462;  pC[0][2] = 478;   pO[0] = 16;
      pC[1][0] = -708;  pC[1][1] = -1390; pC[1][2] = 2098;  pO[1] = 2048 >> m;
      pC[2][0] = 2098;  pC[2][1] = -1757; pC[2][2] = -341;  pO[2] = 2047 >> m;
      pM = m; drivePorts(); idle(4); sweep(250, 17 + m);
    end

    // R5: saturation high and low
    tag = "R5"; setDiag(4095, 100, 2); idle(4); sweep(200, 31);
    tag = "R5"; setDiag(-4096, -3, 0); idle(4); sweep(200, 37);
    tag = "R5"; setDiag(-2048, 4095, 2); idle(4); sweep(200, 41);

    // R3: half values round upward, positive and negative
    tag = "R3"; setDiag(2048, 0, 0); idle(4);
    for (int x = 0; x < 64; x++) tick(1'b1, x, x + 1, 4095 - x);
    tag = "R3"; setDiag(-2048, 2048, 0); idle(4);
    for (int x = 0; x < 64; x++) tick(1'b1, x, x + 3, 4095 - x);
    tag = "R3"; setDiag(1, 0, 0); idle(4);
    for (int x = 2000; x < 2100; x++) tick(1'b1, x, 4095 - x, x + 1000);

    // R9: port changes during a stream, and across a one-cycle gap, are ignored
    tag = "R9"; setDiag(2048, 0, 1); idle(4);
    for (int i = 0; i < 40; i++) begin
      if (i == 10) setDiag(-1000, 3000, 0);
      if (i == 25) tick(1'b0, 0, 0, 0);
      tick(1'b1, i * 97 % 4096, i * 61 % 4096, i * 33 % 4096);
    end
    idle(4);
    for (int i = 0; i < 40; i++) tick(1'b1, i * 97 % 4096, i * 61 % 4096, i * 33 % 4096);

    // R8: sparse valid pattern, outputs must hold between pixels
    tag = "R8"; setDiag(1500, 200, 1); idle(4);
    for (int i = 0; i < 120; i++) tick((i % 3) == 0, i * 53 % 4096, i * 11 % 4096, i * 29 % 4096);
    idle(6);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule